// File: doc/BRIEF.md
# Mid-Bit Tracking Serial Receiver

This block receives asynchronous serial frames on a single line. Each frame is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The block runs from a fast sample clock that need not be a whole multiple of the bit rate. The bit period is supplied as a count of sample clocks with a fractional part. The receiver does not divide the clock by a fixed oversampling ratio. It finds the falling edge of the start bit and takes the middle of that bit as the timing reference for the whole frame. For each later bit it loads a down-counter with the number of clocks to that bit's ideal middle. The fraction left over is carried forward, so rounding errors do not build up across the frame.

Each bit value is taken as a three-sample majority vote around the counter expiry. A start bit whose middle votes high is treated as noise, and the receiver returns to idle. A completed frame raises a one-cycle valid pulse with the byte. A frame whose stop bit votes low raises a one-cycle framing-error pulse instead. After a framing error the receiver waits for the line to return high before it looks for a new start bit. The bit period input must be held stable while a frame is in progress.

Top module: `mbt_uart_rx`

## Requirements
- R1: While reset is high and on the first cycle after it is released, data_valid and frame_err are 0, data_out is 0x00, and the receiver is idle.
- R2: While idle, a low line starts a frame. If the start-bit vote at its middle reads high, the frame is dropped, with no valid pulse and no framing-error pulse, and the receiver returns to idle.
- R3: bit_period is an unsigned 16.8 fixed-point count of clocks per bit, bits 23:8 holding the integer part (at least 4) and bits 7:0 the fraction. Counted from the detection of the falling edge, the sample for frame bit k (0 = start) falls within one clock of (k + 0.5) x bit_period, so the stop sample lands within one clock of 9.5 periods. Successive samples are spaced by the integer part or the integer part plus one.
- R4: Each bit value is the majority of three line samples taken on consecutive clocks around the bit's sample point, so a line disturbance lasting one clock inside a bit does not change the received value.
- R5: The eight data bits are assembled least significant bit first: the first data bit after the start bit becomes data_out bit 0.
- R6: When the stop bit votes high, data_out takes the received byte and data_valid is high for exactly one cycle. data_out keeps its value until the next valid pulse.
- R7: When the stop bit votes low, frame_err is high for exactly one cycle, data_valid stays low for that frame and data_out is unchanged.
- R8: After a framing error, no new frame starts while the line stays low. A new frame is recognized only after the line has been seen high.
- R9: Frames are received correctly when the transmitter's bit period differs from bit_period by up to 2 percent in either direction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_line | input | 1 | Asynchronous serial line, idle high |
| bit_period | input | 24 | Clocks per bit, 16.8 unsigned fixed point |
| data_out | output | 8 | Last correctly framed byte |
| data_valid | output | 1 | One-cycle pulse when data_out is updated |
| frame_err | output | 1 | One-cycle pulse when a stop bit reads low |

## Verification
The valid or framing-error pulse is due floor(9.5 x P + 0.5) + 3 clocks after the clock on which the bench drives the start edge. Two synchronizer stages and the detection register make up the fixed offset. The bench records the cycle of each pulse and checks that it lies within one clock of that figure, which also exposes any loss of the carried fraction. Result counts and the captured byte are read only after a quiet tail of about three bit periods of high line. That tail is long enough for every pulse to have appeared and short enough that no later frame has begun.

// File: rtl/mbt_uart_pkg.sv
package mbt_uart_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_WAIT
  } rx_state_t;
endpackage

// File: rtl/mbt_rx_sync.sv
module mbt_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_in,
  output logic rx_s,
  output logic vote
);
  localparam int W = STAGES + 2;

  logic [W-1:0] sr_q;
  logic         h1, h2;

  always_ff @(posedge clk) begin
    if (rst) sr_q <= '1;
    else     sr_q <= {sr_q[W-2:0], rx_in};
  end

  assign rx_s = sr_q[STAGES-1];
  assign h1   = sr_q[STAGES];
  assign h2   = sr_q[STAGES+1];
  // three consecutive samples, centred one clock behind rx_s
  assign vote = (rx_s & h1) | (rx_s & h2) | (h1 & h2);
endmodule

// File: rtl/mbt_rx_timer.sv
module mbt_rx_timer #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    run,
  input  logic [INT_W+FRAC_W-1:0] bit_period,
  output logic                    tick
);
  localparam int W = INT_W + FRAC_W;
  localparam logic [W:0] ONE = (W+1)'(1) << FRAC_W;

  logic [INT_W-1:0]  cnt_q;
  logic [FRAC_W-1:0] frac_q;
  logic [W:0]        first_sum, next_sum;
  logic [INT_W:0]    first_int, next_int;

  // half a period plus one half clock, for rounding to the nearest clock
  assign first_sum = ({1'b0, bit_period} + ONE) >> 1;
  assign first_int = first_sum[W:FRAC_W];
  // one full period plus the carried fraction
  assign next_sum  = {1'b0, bit_period} + {{(INT_W+1){1'b0}}, frac_q};
  assign next_int  = next_sum[W:FRAC_W];

  assign tick = run && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      frac_q <= '0;
    end else if (load) begin
      cnt_q  <= INT_W'(first_int - 1'b1);
      frac_q <= first_sum[FRAC_W-1:0];
    end else if (tick) begin
      cnt_q  <= INT_W'(next_int - 1'b1);
      frac_q <= next_sum[FRAC_W-1:0];
    end else if (run) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  // spacing monitor for the assertion below
  logic [INT_W:0] gap_q;
  logic           first_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap_q   <= '0;
      first_q <= 1'b1;
    end else if (load) begin
      gap_q   <= (INT_W+1)'(1);
      first_q <= 1'b1;
    end else if (tick) begin
      gap_q   <= (INT_W+1)'(1);
      first_q <= 1'b0;
    end else if (gap_q != '1) begin
      gap_q   <= gap_q + 1'b1;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
    (tick && !first_q) |-> (gap_q == {1'b0, bit_period[W-1:FRAC_W]} ||
                            gap_q == {1'b0, bit_period[W-1:FRAC_W]} + 1'b1)); // R3
endmodule

// File: rtl/mbt_rx_frame.sv
module mbt_rx_frame
  import mbt_uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_s,
  input  logic              vote,
  input  logic              tick,
  output logic              load,
  output logic              run,
  output logic [DATA_W-1:0] data_out,
  output logic              data_valid,
  output logic              frame_err
);
  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  rx_state_t         state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] shreg_q, data_q;
  logic              valid_q, ferr_q;

  assign load = (state_q == ST_IDLE) && !rx_s;
  assign run  = (state_q == ST_START) || (state_q == ST_DATA) || (state_q == ST_STOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      shreg_q <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      case (state_q)
        ST_IDLE:  if (!rx_s) state_q <= ST_START;
        ST_START: if (tick) begin
          if (vote) state_q <= ST_IDLE;
          else begin
            state_q <= ST_DATA;
            idx_q   <= '0;
          end
        end
        ST_DATA:  if (tick) begin
          shreg_q <= {vote, shreg_q[DATA_W-1:1]};
          if (idx_q == IDX_W'(DATA_W-1)) state_q <= ST_STOP;
          else                           idx_q   <= idx_q + 1'b1;
        end
        ST_STOP:  if (tick) begin
          if (vote) begin
            data_q  <= shreg_q;
            valid_q <= 1'b1;
            state_q <= ST_IDLE;
          end else begin
            ferr_q  <= 1'b1;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT:  if (rx_s) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign data_out   = data_q;
  assign data_valid = valid_q;
  assign frame_err  = ferr_q;

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    data_valid |=> !data_valid); // R6
  AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !data_valid |-> $stable(data_out)); // R6
  AST_NO_VALID_ON_ERR: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> !data_valid); // R7
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> !frame_err); // R7
  AST_WAIT_FOR_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !rx_s) |=> (state_q == ST_WAIT)); // R8
endmodule

// File: rtl/mbt_uart_rx.sv
module mbt_uart_rx #(
  parameter int INT_W       = 16,
  parameter int FRAC_W      = 8,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rx_line,
  input  logic [INT_W+FRAC_W-1:0] bit_period,
  output logic [DATA_W-1:0]       data_out,
  output logic                    data_valid,
  output logic                    frame_err
);
  logic rx_s, vote, tick, load, run;

  mbt_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .rx_in (rx_line),
    .rx_s  (rx_s),
    .vote  (vote)
  );

  mbt_rx_timer #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .run        (run),
    .bit_period (bit_period),
    .tick       (tick)
  );

  mbt_rx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .rx_s       (rx_s),
    .vote       (vote),
    .tick       (tick),
    .load       (load),
    .run        (run),
    .data_out   (data_out),
    .data_valid (data_valid),
    .frame_err  (frame_err)
  );
endmodule

// File: tb/mbt_uart_rx_bench.sv
module mbt_uart_rx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_line = 1'b1;
  logic [23:0] bit_period = 24'h001000;
  logic [7:0]  data_out;
  logic        data_valid, frame_err;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int nvalid = 0, nferr = 0, valid_cyc = 0, fstart = 0;
  logic [7:0] last_data = 8'h00;

  always #4 clk = ~clk;

  mbt_uart_rx u_mbt_uart_rx (
    .clk        (clk),
    .rst        (rst),
    .rx_line    (rx_line),
    .bit_period (bit_period),
    .data_out   (data_out),
    .data_valid (data_valid),
    .frame_err  (frame_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (data_valid) begin
      nvalid    = nvalid + 1;
      last_data = data_out;
      valid_cyc = cyc;
    end
    if (frame_err) nferr = nferr + 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // frame bits: 0 start, 1..8 data LSB first, 9 stop
  task automatic send_frame(input logic [7:0] b, input int txp, input logic stopv,
                            input int gbit, input int low_hold);
    int c;
    int bi;
    logic lv;
    nvalid = 0;
    nferr  = 0;
    @(negedge clk);
    fstart = cyc;
    c = 0;
    forever begin
      bi = (c * 256) / txp;
      if (bi >= 10) break;
      lv = (bi == 0) ? 1'b0 : (bi == 9) ? stopv : b[bi-1];
      if (bi == gbit && ((c * 256 - bi * txp) / 256) == 8) lv = ~lv;
      rx_line = lv;
      @(negedge clk);
      c++;
    end
    if (low_hold > 0) begin
      rx_line = 1'b0;
      repeat (low_hold) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (txp * 3 / 256 + 12) @(negedge clk);
  endtask

  // byte, rx period, tx period, stop level, expect valid, expect error
  localparam logic [58:0] VEC [8] = '{
    {8'hA5, 24'h001000, 24'h001000, 1'b1, 1'b1, 1'b0},
    {8'h3C, 24'h0010C0, 24'h0010C0, 1'b1, 1'b1, 1'b0},
    {8'h01, 24'h0004E6, 24'h0004E6, 1'b1, 1'b1, 1'b0},
    {8'hFE, 24'h004119, 24'h004119, 1'b1, 1'b1, 1'b0},
    {8'h5A, 24'h001000, 24'h001052, 1'b1, 1'b1, 1'b0},
    {8'hC3, 24'h001000, 24'h000FAE, 1'b1, 1'b1, 1'b0},
    {8'h80, 24'h000855, 24'h000855, 1'b1, 1'b1, 1'b0},
    {8'h96, 24'h001000, 24'h001000, 1'b0, 1'b0, 1'b1}
  };

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] prev;
    repeat (5) @(negedge clk);
    chk(data_valid == 1'b0, "R1 valid in reset", data_valid, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(data_valid == 1'b0, "R1 valid after reset", data_valid, 0);
    chk(frame_err == 1'b0, "R1 frame_err after reset", frame_err, 0);
    chk(data_out == 8'h00, "R1 data_out after reset", data_out, 0);
    repeat (4) @(negedge clk);

    prev = 8'h00;
    for (int i = 0; i < 8; i++) begin
      logic [7:0]  vb;
      logic [23:0] vr, vt;
      logic        vs, ev, ef;
      int          tcyc;
      {vb, vr, vt, vs, ev, ef} = VEC[i];
      bit_period = vr;
      send_frame(vb, int'(vt), vs, -1, 0);
      chk(nvalid == int'(ev), $sformatf("R6 R9 vec%0d valid count", i), nvalid, ev);
      chk(nferr == int'(ef), $sformatf("R7 vec%0d error count", i), nferr, ef);
      if (ev) begin
        chk(last_data == vb, $sformatf("R5 vec%0d byte", i), last_data, vb);
        if (vr == vt) begin
          tcyc = (19 * int'(vr) + 256) / 512 + 3;
          chk((valid_cyc - fstart) >= tcyc - 1 && (valid_cyc - fstart) <= tcyc + 1,
              $sformatf("R3 vec%0d valid timing", i), valid_cyc - fstart, tcyc);
        end
        prev = vb;
      end else begin
        chk(data_out == prev, $sformatf("R7 vec%0d data_out unchanged", i), data_out, prev);
      end
    end

    // R4: one-clock disturbances inside data bits
    bit_period = 24'h001000;
    send_frame(8'hA5, 256 * 16, 1'b1, 3, 0);
    chk(nvalid == 1 && last_data == 8'hA5, "R4 glitch on a one bit", last_data, 8'hA5);
    send_frame(8'hA5, 256 * 16, 1'b1, 2, 0);
    chk(nvalid == 1 && last_data == 8'hA5, "R4 glitch on a zero bit", last_data, 8'hA5);

    // R2: short low pulse is not a start bit
    nvalid = 0;
    nferr  = 0;
    @(negedge clk);
    rx_line = 1'b0;
    repeat (4) @(negedge clk);
    rx_line = 1'b1;
    repeat (200) @(negedge clk);
    chk(nvalid == 0, "R2 short pulse no valid", nvalid, 0);
    chk(nferr == 0, "R2 short pulse no error", nferr, 0);
    send_frame(8'h42, 256 * 16, 1'b1, -1, 0);
    chk(nvalid == 1 && last_data == 8'h42, "R2 frame after rejected start", last_data, 8'h42);

    // R8: after a framing error with the line held low, no frame may start
    send_frame(8'h11, 256 * 16, 1'b0, -1, 40);
    chk(nferr == 1, "R8 one framing error", nferr, 1);
    chk(nvalid == 0, "R8 no frame while line low", nvalid, 0);
    chk(data_out == 8'h42, "R6 data_out held after error", data_out, 8'h42);
    send_frame(8'h77, 256 * 16, 1'b1, -1, 0);
    chk(nvalid == 1 && last_data == 8'h77, "R8 frame after line high", last_data, 8'h77);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule